// File: doc/BRIEF.md
# Variable-Frequency Fixed-Deadtime Pulse Generator

This block is the digital timing core of a resonant-mode power controller. Each switching cycle opens with a short recharge phase. A timing phase follows, and its length is set by a frequency control word. A one-shot timer is armed in the same recharge phase as the oscillator. When the timing phase begins, the one-shot starts and drives the deadtime output high. The deadtime output stays high until the one-shot expires, and both power switches must be off for that whole time. The frequency changes with the control word, while the off-time stays fixed at the programmed one-shot length.

The control word stands in for an error-amplifier voltage. A word of zero selects the longest period, which is the lowest frequency. A word of all ones selects the shortest period, which is the highest frequency. With the default parameters the period runs from 4 to 4096 clocks, a range of 1024:1. A hold input stands for undervoltage lockout or a latched fault. While hold is high, the block stays recharged and starts no cycle. A one-clock strobe marks the start of every deadtime pulse.

The states are HOLD, CHARGE, FIRE, DEAD and LIVE:
- HOLD: the block is held. It moves to CHARGE once hold is low.
- CHARGE: the recharge phase. It lasts `RCHG_CYC` clocks, then moves to FIRE and samples the inputs.
- FIRE: the first timing cycle. It raises the strobe, then moves to DEAD, or straight to LIVE if the one-shot has already expired.
- DEAD: the one-shot is running. It moves to LIVE when the one-shot expires.
- LIVE: the rest of the timing phase. It moves to CHARGE when the oscillator expires.
- From any state, hold high moves the block to HOLD.

Top module: `vfdt_core`

## Requirements
- R1: While reset is active, and while hold stays high after reset, `dead_o` and `strobe_o` are both 0.
- R2: The base timing length is T = `TMR_MIN` + `STEP`*(2^`CTRL_W`-1-`ctrl_i`). The strobe-to-strobe interval is `RCHG_CYC` + T clocks. A control word of 0 gives the longest interval and a word of all ones gives the shortest.
- R3: `dead_o` is high for exactly L consecutive clocks, starting with the strobe clock. L = `os_len_i`, except that a value of 0 is treated as 1.
- R4: The timing length is raised to L+1 whenever T is smaller, so every cycle has at least one clock with `dead_o` low before the next recharge.
- R5: `ctrl_i` and `os_len_i` are sampled only in the last CHARGE clock. A change made during a cycle affects only the next cycle.
- R6: `strobe_o` is one clock wide. It is high exactly in the first clock of each `dead_o` pulse.
- R7: In the clock after `hold_i` is sampled high, `dead_o` and `strobe_o` are 0. They stay 0 for as long as hold is sampled high.
- R8: `hold_i` may be sampled low at a clock edge. Counting that edge as the first, the first strobe appears after edge `RCHG_CYC`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | CTRL_W | Frequency control word (higher = faster) |
| os_len_i | input | OS_W | One-shot (deadtime) length in clocks |
| hold_i | input | 1 | Hold/disable (lockout or fault) |
| dead_o | output | 1 | Deadtime pulse, both switches off |
| strobe_o | output | 1 | One-clock cycle-start strobe |

## Verification
The assertions rely on `RCHG_CYC` being at least 1. The minimum-interval property relies on the block's own clamp, which keeps every timing phase at least two clocks long. They also take for granted that `hold_i` is a clean synchronous level, so the release-latency count begins where hold is sampled low. The stimulus drives every input on the falling clock edge. It changes the control word and one-shot length at strobe time or mid-cycle, and changes them during hold, so that each sampled value is unambiguous. It sweeps every pairing of the two inputs on a 4-bit configuration.

// File: rtl/vfdt_pkg.sv
package vfdt_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_CHARGE = 3'd1,
        ST_FIRE   = 3'd2,
        ST_DEAD   = 3'd3,
        ST_LIVE   = 3'd4
    } vfdt_state_e;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vfdt_timer.sv
module vfdt_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/vfdt_period_map.sv
module vfdt_period_map #(
    parameter int CTRL_W  = 10,
    parameter int OS_W    = 8,
    parameter int STEP    = 4,
    parameter int TMR_MIN = 2,
    parameter int CNT_W   = 12
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [OS_W-1:0]   os_len_i,
    output logic [CNT_W-1:0]  t_eff_o,
    output logic [CNT_W-1:0]  l_eff_o
);
    logic [CTRL_W-1:0] inv;
    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  t_raw;
    logic [CNT_W-1:0]  floor_len;

    // distance from the fastest setting
    assign inv = ~ctrl_i;

    generate
        if (STEP == 1) begin : g_unit_step
            assign span = CNT_W'(inv);
        end else begin : g_scaled_step
            assign span = CNT_W'(inv) * CNT_W'(STEP);
        end
    endgenerate

    always_comb begin
        t_raw     = CNT_W'(TMR_MIN) + span;
        l_eff_o   = (os_len_i == '0) ? CNT_W'(1) : CNT_W'(os_len_i);
        floor_len = l_eff_o + CNT_W'(1);
        t_eff_o   = (t_raw < floor_len) ? floor_len : t_raw;
    end

endmodule

// File: rtl/vfdt_fsm.sv
module vfdt_fsm
    import vfdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic chg_zero_i,
    input  logic os_zero_i,
    input  logic osc_zero_i,
    output logic chg_load_o,
    output logic chg_dec_o,
    output logic arm_o,
    output logic osc_dec_o,
    output logic os_dec_o,
    output logic dead_o,
    output logic strobe_o
);
    vfdt_state_e st_q, st_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st_q;
        if (hold_i) begin
            st_nxt = ST_HOLD;
        end else begin
            unique case (st_q)
                ST_HOLD:   st_nxt = ST_CHARGE;
                ST_CHARGE: if (chg_zero_i) st_nxt = ST_FIRE;
                ST_FIRE,
                ST_DEAD:   st_nxt = os_zero_i ? ST_LIVE : ST_DEAD;
                ST_LIVE:   if (osc_zero_i) st_nxt = ST_CHARGE;
                default:   st_nxt = ST_HOLD;
            endcase
        end
    end

    // outputs and timer controls
    always_comb begin
        chg_load_o = 1'b0;
        chg_dec_o  = 1'b0;
        arm_o      = 1'b0;
        osc_dec_o  = 1'b0;
        os_dec_o   = 1'b0;
        dead_o     = 1'b0;
        strobe_o   = 1'b0;
        unique case (st_q)
            ST_HOLD: begin
                chg_load_o = !hold_i;
            end
            ST_CHARGE: begin
                chg_dec_o = !hold_i;
                arm_o     = !hold_i && chg_zero_i;
            end
            ST_FIRE: begin
                osc_dec_o = 1'b1;
                os_dec_o  = 1'b1;
                dead_o    = 1'b1;
                strobe_o  = 1'b1;
            end
            ST_DEAD: begin
                osc_dec_o = 1'b1;
                os_dec_o  = 1'b1;
                dead_o    = 1'b1;
            end
            ST_LIVE: begin
                osc_dec_o  = 1'b1;
                chg_load_o = !hold_i && osc_zero_i;
            end
            default: begin
                chg_load_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vfdt_core.sv
module vfdt_core #(
    parameter int CTRL_W   = 10,
    parameter int OS_W     = 8,
    parameter int STEP     = 4,
    parameter int TMR_MIN  = 2,
    parameter int RCHG_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [OS_W-1:0]   os_len_i,
    input  logic              hold_i,
    output logic              dead_o,
    output logic              strobe_o
);
    localparam int TMR_MAX = TMR_MIN + ((1 << CTRL_W) - 1) * STEP;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int CNT_W   = vfdt_pkg::max_i(TMR_W, OS_W + 1);
    localparam int CHG_W   = (RCHG_CYC > 1) ? $clog2(RCHG_CYC) : 1;

    logic [CNT_W-1:0] t_eff, l_eff;
    logic chg_load, chg_dec, arm, osc_dec, os_dec;
    logic chg_zero, os_zero, osc_zero;

    vfdt_period_map #(
        .CTRL_W (CTRL_W),
        .OS_W   (OS_W),
        .STEP   (STEP),
        .TMR_MIN(TMR_MIN),
        .CNT_W  (CNT_W)
    ) u_map (
        .ctrl_i  (ctrl_i),
        .os_len_i(os_len_i),
        .t_eff_o (t_eff),
        .l_eff_o (l_eff)
    );

    vfdt_timer #(.W(CHG_W)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(chg_load),
        .val_i (CHG_W'(RCHG_CYC - 1)),
        .dec_i (chg_dec),
        .zero_o(chg_zero)
    );

    vfdt_timer #(.W(CNT_W)) u_osc (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(arm),
        .val_i (t_eff - CNT_W'(1)),
        .dec_i (osc_dec),
        .zero_o(osc_zero)
    );

    vfdt_timer #(.W(CNT_W)) u_os (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(arm),
        .val_i (l_eff - CNT_W'(1)),
        .dec_i (os_dec),
        .zero_o(os_zero)
    );

    vfdt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (hold_i),
        .chg_zero_i(chg_zero),
        .os_zero_i (os_zero),
        .osc_zero_i(osc_zero),
        .chg_load_o(chg_load),
        .chg_dec_o (chg_dec),
        .arm_o     (arm),
        .osc_dec_o (osc_dec),
        .os_dec_o  (os_dec),
        .dead_o    (dead_o),
        .strobe_o  (strobe_o)
    );

endmodule

// File: rtl/vfdt_check.sv
module vfdt_check #(
    parameter int OS_W     = 8,
    parameter int RCHG_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic hold_i,
    input logic dead_o,
    input logic strobe_o
);
    localparam int MAXL    = (1 << OS_W) - 1;
    localparam int MIN_GAP = RCHG_CYC + 2;

    logic [15:0] gap_q, len_q, rel_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            len_q  <= '0;
            rel_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (strobe_o)              gap_q <= 16'd1;
            else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
            if (strobe_o) seen_q <= 1'b1;
            if (!dead_o)               len_q <= '0;
            else if (len_q != 16'hFFFF) len_q <= len_q + 16'd1;
            if (hold_i)                rel_q <= '0;
            else if (rel_q != 16'hFFFF) rel_q <= rel_q + 16'd1;
        end
    end

    assert_strobe_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dead_o) |-> strobe_o);

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!dead_o && !strobe_o));

    assert_min_interval_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && seen_q) |-> (32'(gap_q) >= MIN_GAP));

    assert_dead_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dead_o |-> (32'(len_q) < MAXL));

    assert_release_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (32'(rel_q) >= RCHG_CYC + 1));

endmodule

bind vfdt_core vfdt_check #(
    .OS_W    (OS_W),
    .RCHG_CYC(RCHG_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold_i),
    .dead_o  (dead_o),
    .strobe_o(strobe_o)
);

// File: tb/vfdt_core_test.sv
`timescale 1ns/1ps
module vfdt_core_test;
    localparam int CW = 4, OW = 4, STP = 3, TMIN = 2, RCH = 2;
    localparam int LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] ctrl = '0;
    logic [OW-1:0] osl = '0;
    logic          hold = 1'b1;
    logic          dead, strobe;

    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  timed_out = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    vfdt_core #(.CTRL_W(CW), .OS_W(OW), .STEP(STP), .TMR_MIN(TMIN), .RCHG_CYC(RCH)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .os_len_i(osl),
        .hold_i(hold), .dead_o(dead), .strobe_o(strobe));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int o);
        return (o == 0) ? 1 : o;
    endfunction

    function automatic int raw_tim(input int c);
        return TMIN + STP * ((1 << CW) - 1 - c);
    endfunction

    function automatic int exp_tim(input int c, input int o);
        int t = raw_tim(c);
        if (t < exp_len(o) + 1) t = exp_len(o) + 1;
        return t;
    endfunction

    task automatic step();
        @(negedge clk);
        if (cyc > LIMIT) timed_out = 1'b1;
    endtask

    task automatic to_strobe(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!strobe && !timed_out);
    endtask

    // starts on a strobe clock, ends on the next strobe clock
    task automatic measure(input int ew, input int ei, input string tw, input string ti,
                           input int chg_at, input int nc, input int no);
        int w = 1, n = 0;
        chk(dead === 1'b1, "R6", int'(dead), 1);
        do begin
            step();
            n++;
            if (n == 1) chk(strobe === 1'b0, "R6", int'(strobe), 0);
            if (n == chg_at) begin
                ctrl = CW'(nc);
                osl  = OW'(no);
            end
            if (!strobe && dead) w++;
        end while (!strobe && !timed_out);
        chk(w == ew, tw, w, ew);
        chk(n == ei, ti, n, ei);
    endtask

    initial begin
        int n;
        // R1: reset and held state
        repeat (3) step();
        chk(dead === 1'b0, "R1", int'(dead), 0);
        chk(strobe === 1'b0, "R1", int'(strobe), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(dead === 1'b0 && strobe === 1'b0, "R1", int'(dead), 0);
        end

        // R8: release latency
        ctrl = CW'(5);
        osl  = OW'(4);
        hold = 1'b0;
        to_strobe(n);
        chk(n == RCH + 1, "R8", n, RCH + 1);
        measure(exp_len(4), RCH + exp_tim(5, 4), "R3", "R2", -1, 0, 0);

        // R2/R3/R4: every control word with every one-shot length
        for (int c = 0; c < (1 << CW); c++) begin
            for (int o = 0; o < (1 << OW); o++) begin
                ctrl = CW'(c);
                osl  = OW'(o);
                to_strobe(n);
                measure(exp_len(o), RCH + exp_tim(c, o), "R3",
                        (raw_tim(c) < exp_len(o) + 1) ? "R4" : "R2", -1, 0, 0);
            end
        end

        // R5: change inside a cycle applies only to the next one
        ctrl = CW'(0);
        osl  = OW'(3);
        to_strobe(n);
        measure(3, RCH + exp_tim(0, 3), "R5", "R5", 1, 15, 9);
        measure(9, RCH + exp_tim(15, 9), "R5", "R5", -1, 0, 0);

        // R7: hold mid-deadtime
        repeat (3) step();
        hold = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            if (i == 4) ctrl = CW'(7);
            chk(dead === 1'b0 && strobe === 1'b0, "R7", int'(dead) + int'(strobe), 0);
        end
        hold = 1'b0;
        to_strobe(n);
        chk(n == RCH + 1, "R8", n, RCH + 1);
        measure(9, RCH + exp_tim(7, 9), "R3", "R2", -1, 0, 0);

        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule